// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block holds a small, fully associative set of virtual-to-physical page mappings and is consulted on every memory access. A lookup that finds a matching valid entry with sufficient rights returns the translated physical address in the same cycle. The low offset bits pass through untranslated, and only the page number is replaced. A lookup that finds no entry raises a miss trap one cycle later, and the trap carries the virtual page number that failed. A lookup that finds an entry lacking the needed right raises a protection trap instead. The block never walks page tables, so it needs no knowledge of their layout.

Trap-handling software refills the buffer through a write port. A written page number that is already present overwrites its own slot. Otherwise the new entry goes into the lowest free slot. When every slot is occupied, a slot is chosen from per-entry reference bits as a cheap stand-in for least-recently-used order. When an occupied slot is replaced, the block reports the departing mapping together with its dirty flag, so software knows whether that page must be written back.

Top module: `xlate_buf`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses, and `trap_miss`, `trap_prot` and `evict_valid` are low.
- R2: A lookup whose page number matches a valid entry with the needed right drives `lk_hit` high in the same cycle. `lk_paddr` is then the stored physical page number with the low 12 offset bits of `lk_vaddr` appended unchanged. The next cycle shows no trap.
- R3: A lookup that matches no valid entry keeps `lk_hit` low. On the next cycle it pulses `trap_miss` for one cycle, and `trap_vpn` equals the looked-up virtual page number.
- R4: Rights field: bit 0 permits reads and bit 1 permits writes. A read that matches an entry with bit 0 clear, or a write that matches an entry with bit 1 clear, keeps `lk_hit` low and pulses `trap_prot` (never together with `trap_miss`) on the next cycle. It leaves the dirty flag untouched.
- R5: A fill places the new entry in the lowest-index invalid slot. A fill whose page number is already present overwrites that entry and reports no eviction.
- R6: A permitted hit sets the entry's reference bit, and a fill sets the reference bit of the entry it writes.
- R7: With every slot valid, a fill replaces the lowest-index entry whose reference bit is clear. If all reference bits are set, it first clears them all and then takes slot 0.
- R8: A permitted write hit sets the entry's dirty flag, and a fill clears it. When a fill replaces a valid entry, `evict_valid` pulses on the next cycle with the departing page numbers and dirty flag.
- R9: With `lk_valid` low, no trap is raised and `lk_hit` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a store (1) or a load (0) |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Permitted translation found (combinational) |
| lk_paddr | output | PA_W | Translated physical address (combinational) |
| trap_miss | output | 1 | Registered pulse: previous lookup missed |
| trap_prot | output | 1 | Registered pulse: previous lookup lacked rights |
| trap_vpn | output | VA_W-12 | Page number of the trapping lookup |
| fill_en | input | 1 | Write a new entry |
| fill_vpn | input | VA_W-12 | Virtual page number of the new entry |
| fill_ppn | input | PA_W-12 | Physical page number of the new entry |
| fill_rights | input | 2 | Rights of the new entry (bit 0 read, bit 1 write) |
| evict_valid | output | 1 | Registered pulse: a valid entry was replaced |
| evict_vpn | output | VA_W-12 | Virtual page number of the replaced entry |
| evict_ppn | output | PA_W-12 | Physical page number of the replaced entry |
| evict_dirty | output | 1 | Replaced entry had been written |

## Verification
The assertions check several properties on every cycle: offset pass-through on a hit, that the two trap kinds never coincide, that every refused lookup produces exactly one trap carrying its page number, and that evictions and traps only follow a fill or a lookup. Dirty and reference state are internal, so their effect shows only through the order and dirty flags of later evictions. Only the bench's scenarios can show this. The bench fills every slot, sweeps loads and stores over entries with varied rights, and then forces replacements whose victims follow from the earlier hits.

// File: rtl/xb_pkg.sv
package xb_pkg;
   // Access rights of one mapping; rd is bit 0, wr is bit 1.
   typedef struct packed {
      logic wr;
      logic rd;
   } xb_rights_t;

   localparam int unsigned XB_RIGHTS_W = $bits(xb_rights_t);
endpackage

// File: rtl/xb_lowest.sv
// Finds the lowest set bit of a request vector.
module xb_lowest #(
   parameter  int unsigned N  = 16,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/xb_match.sv
// Parallel tag comparison across all entries.
module xb_match #(
   parameter int unsigned N = 16,
   parameter int unsigned W = 20
) (
   input  logic [W-1:0]        key,
   input  logic [N-1:0][W-1:0] tags,
   input  logic [N-1:0]        valid,
   output logic [N-1:0]        hits
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hits[g] = valid[g] && (tags[g] == key);
   end
endmodule

// File: rtl/xb_victim.sv
// Replacement choice: free slot first, then an unreferenced slot,
// else request a global reference clear and take slot 0.
module xb_victim #(
   parameter  int unsigned N  = 16,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  valid,
   input  logic [N-1:0]  refb,
   output logic [IW-1:0] idx,
   output logic          clear_all
);
   logic          free_found, cold_found;
   logic [IW-1:0] free_idx, cold_idx;

   xb_lowest #(.N(N)) i_free (.req(~valid), .found(free_found), .idx(free_idx));
   xb_lowest #(.N(N)) i_cold (.req(~refb),  .found(cold_found), .idx(cold_idx));

   always_comb begin
      clear_all = 1'b0;
      if (free_found) begin
         idx = free_idx;
      end else if (cold_found) begin
         idx = cold_idx;
      end else begin
         idx       = '0;
         clear_all = 1'b1;
      end
   end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
   import xb_pkg::*;
#(
   parameter  int unsigned VA_W    = 32,
   parameter  int unsigned PA_W    = 32,
   parameter  int unsigned OFS_W   = 12,
   parameter  int unsigned ENTRIES = 16,
   localparam int unsigned VPN_W   = VA_W - OFS_W,
   localparam int unsigned PPN_W   = PA_W - OFS_W,
   localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lk_valid,
   input  logic                   lk_write,
   input  logic [VA_W-1:0]        lk_vaddr,
   output logic                   lk_hit,
   output logic [PA_W-1:0]        lk_paddr,
   output logic                   trap_miss,
   output logic                   trap_prot,
   output logic [VPN_W-1:0]       trap_vpn,
   input  logic                   fill_en,
   input  logic [VPN_W-1:0]       fill_vpn,
   input  logic [PPN_W-1:0]       fill_ppn,
   input  logic [XB_RIGHTS_W-1:0] fill_rights,
   output logic                   evict_valid,
   output logic [VPN_W-1:0]       evict_vpn,
   output logic [PPN_W-1:0]       evict_ppn,
   output logic                   evict_dirty
);
   // Elaboration-time parameter checks
   if (OFS_W == 0 || OFS_W >= VA_W) begin : g_bad_va
      $error("xlate_buf: OFS_W must be between 1 and VA_W-1");
   end
   if (OFS_W >= PA_W) begin : g_bad_pa
      $error("xlate_buf: OFS_W must be below PA_W");
   end
   if (ENTRIES < 2) begin : g_bad_n
      $error("xlate_buf: ENTRIES must be at least 2");
   end

   // Entry storage
   logic [ENTRIES-1:0]            v_q, ref_q, dirty_q;
   logic [ENTRIES-1:0]            v_d, ref_d, dirty_d;
   logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
   xb_rights_t [ENTRIES-1:0]      rights_q;

   // Lookup path
   logic [VPN_W-1:0]   lk_vpn;
   logic [ENTRIES-1:0] lk_vec;
   logic               lk_any;
   logic [IDX_W-1:0]   lk_idx;
   xb_rights_t         lk_rights;
   logic               lk_allow;

   assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];

   xb_match #(.N(ENTRIES), .W(VPN_W)) i_lk_match (
      .key(lk_vpn), .tags(vpn_q), .valid(v_q), .hits(lk_vec));
   xb_lowest #(.N(ENTRIES)) i_lk_enc (
      .req(lk_vec), .found(lk_any), .idx(lk_idx));

   assign lk_rights = rights_q[lk_idx];
   assign lk_allow  = lk_write ? lk_rights.wr : lk_rights.rd;
   assign lk_hit    = lk_valid && lk_any && lk_allow;
   assign lk_paddr  = {ppn_q[lk_idx], lk_vaddr[OFS_W-1:0]};

   // Fill path
   logic [ENTRIES-1:0] fl_vec;
   logic               fl_any;
   logic [IDX_W-1:0]   fl_idx;
   logic [IDX_W-1:0]   vic_idx;
   logic               vic_clear;
   logic [IDX_W-1:0]   fl_slot;
   logic               fl_evicts;

   xb_match #(.N(ENTRIES), .W(VPN_W)) i_fl_match (
      .key(fill_vpn), .tags(vpn_q), .valid(v_q), .hits(fl_vec));
   xb_lowest #(.N(ENTRIES)) i_fl_enc (
      .req(fl_vec), .found(fl_any), .idx(fl_idx));
   xb_victim #(.N(ENTRIES)) i_victim (
      .valid(v_q), .refb(ref_q), .idx(vic_idx), .clear_all(vic_clear));

   assign fl_slot   = fl_any ? fl_idx : vic_idx;
   assign fl_evicts = fill_en && !fl_any && v_q[vic_idx];

   // Status next state: fill overrides a hit on the same slot
   always_comb begin
      v_d     = v_q;
      ref_d   = ref_q;
      dirty_d = dirty_q;
      if (fill_en && !fl_any && vic_clear) begin
         ref_d = '0;
      end
      if (lk_hit) begin
         ref_d[lk_idx] = 1'b1;
         if (lk_write) begin
            dirty_d[lk_idx] = 1'b1;
         end
      end
      if (fill_en) begin
         v_d[fl_slot]     = 1'b1;
         ref_d[fl_slot]   = 1'b1;
         dirty_d[fl_slot] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q         <= '0;
         ref_q       <= '0;
         dirty_q     <= '0;
         trap_miss   <= 1'b0;
         trap_prot   <= 1'b0;
         trap_vpn    <= '0;
         evict_valid <= 1'b0;
         evict_vpn   <= '0;
         evict_ppn   <= '0;
         evict_dirty <= 1'b0;
      end else begin
         v_q         <= v_d;
         ref_q       <= ref_d;
         dirty_q     <= dirty_d;
         trap_miss   <= lk_valid && !lk_any;
         trap_prot   <= lk_valid && lk_any && !lk_allow;
         if (lk_valid && !lk_hit) begin
            trap_vpn <= lk_vpn;
         end
         evict_valid <= fl_evicts;
         if (fl_evicts) begin
            evict_vpn   <= vpn_q[vic_idx];
            evict_ppn   <= ppn_q[vic_idx];
            evict_dirty <= dirty_q[vic_idx];
         end
      end
   end

   // Mapping payload, no reset: guarded by the valid bits
   always_ff @(posedge clk) begin
      if (fill_en) begin
         vpn_q[fl_slot]    <= fill_vpn;
         ppn_q[fl_slot]    <= fill_ppn;
         rights_q[fl_slot] <= xb_rights_t'(fill_rights);
      end
   end
endmodule

// File: rtl/xb_chk.sv
module xb_chk #(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned PA_W  = 32,
   parameter int unsigned OFS_W = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  lk_valid,
   input logic [VA_W-1:0]       lk_vaddr,
   input logic                  lk_hit,
   input logic [PA_W-1:0]       lk_paddr,
   input logic                  trap_miss,
   input logic                  trap_prot,
   input logic [VA_W-OFS_W-1:0] trap_vpn,
   input logic                  fill_en,
   input logic                  evict_valid
);
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]); // R2
   AST_HIT_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_hit) |=> (!trap_miss && !trap_prot)); // R2
   AST_REFUSED_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_hit) |=> (trap_miss || trap_prot)); // R3
   AST_TRAP_VPN: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_miss || trap_prot) |-> trap_vpn == $past(lk_vaddr[VA_W-1:OFS_W])); // R3
   AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_miss && trap_prot)); // R4
   AST_EVICT_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> $past(fill_en)); // R8
   AST_TRAP_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_miss || trap_prot) |-> $past(lk_valid)); // R9
   AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_valid); // R9
endmodule

bind xlate_buf xb_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) i_xb_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
   .lk_hit(lk_hit), .lk_paddr(lk_paddr), .trap_miss(trap_miss),
   .trap_prot(trap_prot), .trap_vpn(trap_vpn), .fill_en(fill_en),
   .evict_valid(evict_valid));

// File: tb/test_xlate_buf.sv
module test_xlate_buf;
   localparam int CLK_PERIOD = 10;
   localparam int VA_W = 32, PA_W = 32, OFS_W = 12, N = 16;
   localparam int VPN_W = VA_W - OFS_W, PPN_W = PA_W - OFS_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_valid = 1'b0, lk_write = 1'b0;
   logic [VA_W-1:0] lk_vaddr = '0;
   logic lk_hit, trap_miss, trap_prot, evict_valid, evict_dirty;
   logic [PA_W-1:0] lk_paddr;
   logic [VPN_W-1:0] trap_vpn, evict_vpn;
   logic [PPN_W-1:0] evict_ppn;
   logic fill_en = 1'b0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PPN_W-1:0] fill_ppn = '0;
   logic [1:0] fill_rights = '0;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlate_buf #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ENTRIES(N)) i_xlate_buf (.*);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Table of the bench's own mappings: rights bit0 read, bit1 write
   function automatic logic [PPN_W-1:0] ppn_of(int i); return PPN_W'(32'h40 + i*3); endfunction
   function automatic bit rd_of(int i); return i != 6; endfunction
   function automatic bit wr_of(int i); return (i % 3) != 0; endfunction

   logic r_hit, r_tm, r_tp;
   logic [PA_W-1:0] r_pa;
   logic [VPN_W-1:0] r_tv;

   task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFS_W-1:0] ofs, input bit wr, input bit vld);
      @(negedge clk);
      lk_valid = vld; lk_write = wr; lk_vaddr = {vpn, ofs};
      #1;
      r_hit = lk_hit; r_pa = lk_paddr;
      @(negedge clk);
      lk_valid = 1'b0;
      r_tm = trap_miss; r_tp = trap_prot; r_tv = trap_vpn;
   endtask

   task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn, input logic [1:0] rights);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rights = rights;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic expect_evict(input bit ev, input logic [VPN_W-1:0] vpn,
                               input logic [PPN_W-1:0] ppn, input bit dirty, input string req);
      chk(evict_valid == ev, req, evict_valid, ev);
      if (ev) begin
         chk(evict_vpn == vpn, req, evict_vpn, vpn);
         chk(evict_ppn == ppn, req, evict_ppn, ppn);
         chk(evict_dirty == dirty, req, evict_dirty, dirty);
      end
   endtask

   task automatic expect_hit(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                             input logic [OFS_W-1:0] ofs, input bit wr, input string req);
      lookup(vpn, ofs, wr, 1'b1);
      chk(r_hit == 1'b1, req, r_hit, 1);
      chk(r_pa == {ppn, ofs}, req, r_pa, {ppn, ofs});
      chk(!r_tm && !r_tp, req, {r_tm, r_tp}, 0);
   endtask

   task automatic expect_miss(input logic [VPN_W-1:0] vpn, input string req);
      lookup(vpn, 12'h3c5, 1'b0, 1'b1);
      chk(r_hit == 1'b0, req, r_hit, 0);
      chk(r_tm == 1'b1 && r_tp == 1'b0, req, {r_tm, r_tp}, 2'b10);
      chk(r_tv == vpn, req, r_tv, vpn);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!trap_miss && !trap_prot && !evict_valid && !lk_hit, "R1 reset outputs",
          {trap_miss, trap_prot, evict_valid, lk_hit}, 0);
      expect_miss(VPN_W'(5), "R1 empty buffer misses");

      // R5: fill every slot; none of these evicts
      for (int i = 0; i < N; i++) begin
         fill(VPN_W'(32'h100 + i), ppn_of(i), {wr_of(i), rd_of(i)});
         expect_evict(1'b0, '0, '0, 1'b0, "R5 fill into free slot");
      end

      // R2/R4/R8: sweep loads and stores over every entry
      for (int i = 0; i < N; i++) begin
         logic [OFS_W-1:0] ofs;
         ofs = OFS_W'(i * 32'h155 + 7);
         lookup(VPN_W'(32'h100 + i), ofs, 1'b0, 1'b1);
         chk(r_hit == rd_of(i), "R2 load hit by rights", r_hit, rd_of(i));
         if (rd_of(i)) chk(r_pa == {ppn_of(i), ofs}, "R2 load address", r_pa, {ppn_of(i), ofs});
         chk(r_tp == !rd_of(i) && !r_tm, "R4 load protection trap", {r_tm, r_tp}, !rd_of(i));
         lookup(VPN_W'(32'h100 + i), ~ofs, 1'b1, 1'b1);
         chk(r_hit == wr_of(i), "R4 store hit by rights", r_hit, wr_of(i));
         if (wr_of(i)) chk(r_pa == {ppn_of(i), ~ofs}, "R2 store address", r_pa, {ppn_of(i), ~ofs});
         chk(r_tp == !wr_of(i) && !r_tm, "R4 store protection trap", {r_tm, r_tp}, !wr_of(i));
         if (!r_hit) chk(r_tv == VPN_W'(32'h100 + i), "R4 trap page", r_tv, 32'h100 + i);
      end

      // R9: idle lookup with an unmapped address raises nothing
      lookup(VPN_W'(32'h777), 12'h0, 1'b0, 1'b0);
      chk(!r_hit && !r_tm && !r_tp, "R9 idle lookup quiet", {r_hit, r_tm, r_tp}, 0);

      // R7: all references set -> clear all, slot 0 replaced (entry 0 never stored to)
      fill(VPN_W'(32'h200), PPN_W'(32'h80), 2'b11);
      expect_evict(1'b1, VPN_W'(32'h100), ppn_of(0), 1'b0, "R7 all referenced takes slot 0");
      expect_miss(VPN_W'(32'h100), "R3 replaced entry misses");
      expect_hit(VPN_W'(32'h200), PPN_W'(32'h80), 12'habc, 1'b0, "R2 new entry hits");

      // R6: touch entry 2 so it is skipped
      expect_hit(VPN_W'(32'h102), ppn_of(2), 12'h011, 1'b0, "R6 reference hit");
      fill(VPN_W'(32'h201), PPN_W'(32'h81), 2'b11);
      expect_evict(1'b1, VPN_W'(32'h101), ppn_of(1), 1'b1, "R8 dirty victim slot 1");
      fill(VPN_W'(32'h202), PPN_W'(32'h82), 2'b11);
      expect_evict(1'b1, VPN_W'(32'h103), ppn_of(3), 1'b0, "R7 skips referenced slot 2");

      // R5: overwrite an existing page number in place
      fill(VPN_W'(32'h104), PPN_W'(32'h99), 2'b11);
      expect_evict(1'b0, '0, '0, 1'b0, "R5 overwrite reports no eviction");
      expect_hit(VPN_W'(32'h104), PPN_W'(32'h99), 12'hfff, 1'b1, "R5 overwrite new mapping");

      // R8: overwrite cleared dirty on slot 4, then slot 5 (stored to) is next
      fill(VPN_W'(32'h203), PPN_W'(32'h83), 2'b11);
      expect_evict(1'b1, VPN_W'(32'h105), ppn_of(5), 1'b1, "R8 dirty victim slot 5");
      fill(VPN_W'(32'h204), PPN_W'(32'h84), 2'b11);
      expect_evict(1'b1, VPN_W'(32'h106), ppn_of(6), 1'b0, "R8 clean victim slot 6");

      // R8: a pulse lasts one cycle
      @(negedge clk);
      chk(evict_valid == 1'b0, "R8 eviction pulse ends", evict_valid, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule